// File: doc/BRIEF.md
# Selective Cell Retransmission Fragment Builder

This block builds one retransmission fragment for a frame of cells already held in a cell buffer. A request carries three things: the frame's 24-bit sequence number, the rest of its header image, and a 64-bit selection map that names the cells to resend. Once the block accepts a request, it emits one fragment header cell. After that it emits only the selected data cells, lowest cell number first. It fetches each payload from the buffer through a combinational read port.

Every emitted cell carries a one-byte prefix. The top two bits hold the cell kind: `00` for a data cell, `01` for a fragment header cell, `10` for a redundancy cell, and `11` reserved. The low six bits hold the cell sequence number. A cell is therefore identified by the frame sequence number together with a cell number that restarts in every frame. The output stream uses a valid/ready handshake and carries start and end markers for the fragment.

The header cell payload is laid out as follows. Bits [23:0] hold the frame sequence number, bits [87:24] hold the selection map, and bits [143:88] hold the header image. All higher bits are zero.

Top module: `frag_builder`

## Requirements
- R1: After reset the block is idle. `reqReady` is 1 and `outValid` is 0.
- R2: A request is taken only while `reqReady` is 1, and `reqReady` is 0 whenever a fragment is being emitted. A `reqValid` raised during a fragment has no effect on the cells that follow.
- R3: The first cell of every fragment has `outSof`=1 and prefix 8'h40 (kind `01`, number 0). Its payload carries the frame sequence number in [23:0], the map in [87:24] and the header image in [143:88], with zeros above.
- R4: Each selected cell is emitted with prefix {2'b00, n}, where n is its cell number, and with the buffer word at address n as payload. Selected cells appear in strictly increasing n.
- R5: Cells whose map bit is clear are skipped without an idle cycle. With `outReady` held high, a map with k set bits puts its last cell out k cycles after the header cell.
- R6: `outEof` is 1 only on the final cell of a fragment. An all-zero map yields just the header cell, with `outEof`=1.
- R7: While `outValid`=1 and `outReady`=0, every output holds its value into the next cycle.
- R8: In the cycle after the end cell is accepted, `outValid` is 0 and `reqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Fragment request present |
| reqReady | output | 1 | Block is idle and takes a request |
| reqFsn | input | 24 | Frame sequence number |
| reqHdr | input | 56 | Remaining frame header image |
| reqMap | input | 64 | Selection map, bit n picks cell n |
| rdAddr | output | 6 | Cell buffer read address |
| rdData | input | 384 | Cell buffer read data, same cycle |
| outValid | output | 1 | Output cell valid |
| outReady | input | 1 | Downstream takes the cell |
| outData | output | 384 | Cell payload |
| outPrefix | output | 8 | Cell kind (2 bits) and cell number (6 bits) |
| outSof | output | 1 | First cell of fragment |
| outEof | output | 1 | Last cell of fragment |

## Verification
A wrong remaining-map register shows up at the ports at once: a duplicated, missing or reordered cell number appears in the prefix on the very next accepted cell, and a wrong end marker appears on the cell that should have been last. A wrong state register shows in the same cycle, either as an idle gap between cells or as `reqReady` rising while a fragment is still open. Backpressure faults show one cycle after any stalled cycle, as a change in the held outputs.

// File: rtl/frag_pkg.sv
package frag_pkg;
  typedef enum logic [1:0] {
    KIND_DATA   = 2'b00,
    KIND_HEADER = 2'b01,
    KIND_REDUND = 2'b10,
    KIND_RSVD   = 2'b11
  } cellKind_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic selHead;
  } fragStrobe_t;
endpackage

// File: rtl/frag_ctrl.sv
module frag_ctrl
  import frag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        outReady,
  output logic        outValid,
  output logic        outSof,
  output logic        outEof,
  input  logic        remEmpty,
  input  logic        remLast,
  output fragStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_HEAD, ST_BODY} state_e;
  state_e state, stateNext;
  logic fire;

  assign fire = outValid && outReady;

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    reqReady       = 1'b0;
    outValid       = 1'b0;
    outSof         = 1'b0;
    outEof         = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.load = 1'b1;
          stateNext   = ST_HEAD;
        end
      end
      ST_HEAD: begin
        outValid       = 1'b1;
        outSof         = 1'b1;
        outEof         = remEmpty;
        strobe.selHead = 1'b1;
        if (fire) stateNext = remEmpty ? ST_IDLE : ST_BODY;
      end
      ST_BODY: begin
        outValid = 1'b1;
        outEof   = remLast;
        if (fire) begin
          strobe.advance = 1'b1;
          if (remLast) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end
endmodule

// File: rtl/frag_datapath.sv
module frag_datapath
  import frag_pkg::*;
#(
  parameter int FSN_W     = 24,
  parameter int HDR_W     = 56,
  parameter int MAX_CELLS = 64,
  parameter int PAY_W     = 384,
  localparam int CSN_W    = $clog2(MAX_CELLS),
  localparam int PFX_W    = 2 + CSN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  fragStrobe_t          strobe,
  input  logic [FSN_W-1:0]     reqFsn,
  input  logic [HDR_W-1:0]     reqHdr,
  input  logic [MAX_CELLS-1:0] reqMap,
  output logic [CSN_W-1:0]     rdAddr,
  input  logic [PAY_W-1:0]     rdData,
  output logic [PAY_W-1:0]     outData,
  output logic [PFX_W-1:0]     outPrefix,
  output logic                 remEmpty,
  output logic                 remLast
);
  localparam int MAP_LO = FSN_W;
  localparam int HDR_LO = FSN_W + MAX_CELLS;

  logic [FSN_W-1:0]     fsnQ;
  logic [HDR_W-1:0]     hdrQ;
  logic [MAX_CELLS-1:0] mapQ;
  logic [MAX_CELLS-1:0] remQ;
  logic [CSN_W-1:0]     curIdx;
  logic [PAY_W-1:0]     headCell;

  // lowest set bit of the remaining map
  always_comb begin
    curIdx = '0;
    for (int i = MAX_CELLS - 1; i >= 0; i--) begin
      if (remQ[i]) curIdx = CSN_W'(i);
    end
  end

  assign remEmpty = (remQ == '0);
  assign remLast  = !remEmpty && ((remQ & (remQ - MAX_CELLS'(1))) == '0);
  assign rdAddr   = curIdx;

  always_comb begin
    headCell = '0;
    headCell[FSN_W-1:0]               = fsnQ;
    headCell[MAP_LO +: MAX_CELLS]     = mapQ;
    headCell[HDR_LO +: HDR_W]         = hdrQ;
  end

  assign outData   = strobe.selHead ? headCell : rdData;
  assign outPrefix = strobe.selHead ? {KIND_HEADER, CSN_W'(0)} : {KIND_DATA, curIdx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsnQ <= '0;
      hdrQ <= '0;
      mapQ <= '0;
      remQ <= '0;
    end else if (strobe.load) begin
      fsnQ <= reqFsn;
      hdrQ <= reqHdr;
      mapQ <= reqMap;
      remQ <= reqMap;
    end else if (strobe.advance) begin
      remQ[curIdx] <= 1'b0;
    end
  end
endmodule

// File: rtl/frag_builder.sv
module frag_builder
  import frag_pkg::*;
#(
  parameter int FSN_W     = 24,
  parameter int HDR_W     = 56,
  parameter int MAX_CELLS = 64,
  parameter int PAY_W     = 384,
  localparam int CSN_W    = $clog2(MAX_CELLS),
  localparam int PFX_W    = 2 + CSN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [FSN_W-1:0]     reqFsn,
  input  logic [HDR_W-1:0]     reqHdr,
  input  logic [MAX_CELLS-1:0] reqMap,
  output logic [CSN_W-1:0]     rdAddr,
  input  logic [PAY_W-1:0]     rdData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [PAY_W-1:0]     outData,
  output logic [PFX_W-1:0]     outPrefix,
  output logic                 outSof,
  output logic                 outEof
);
  fragStrobe_t strobe;
  logic remEmpty, remLast;

  frag_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady),
    .outReady(outReady), .outValid(outValid),
    .outSof(outSof), .outEof(outEof),
    .remEmpty(remEmpty), .remLast(remLast),
    .strobe(strobe)
  );

  frag_datapath #(
    .FSN_W(FSN_W), .HDR_W(HDR_W), .MAX_CELLS(MAX_CELLS), .PAY_W(PAY_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .reqFsn(reqFsn), .reqHdr(reqHdr), .reqMap(reqMap),
    .rdAddr(rdAddr), .rdData(rdData),
    .outData(outData), .outPrefix(outPrefix),
    .remEmpty(remEmpty), .remLast(remLast)
  );
endmodule

// File: rtl/frag_builder_chk.sv
module frag_builder_chk #(
  parameter int PAY_W = 384,
  parameter int PFX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqReady,
  input logic             outValid,
  input logic             outReady,
  input logic [PAY_W-1:0] outData,
  input logic [PFX_W-1:0] outPrefix,
  input logic             outSof,
  input logic             outEof
);
  localparam int CSN_W = PFX_W - 2;

  p_busy_blocks_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !outValid);

  p_header_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> (outValid && outSof && outPrefix == {2'b01, CSN_W'(0)}));

  p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && !outSof && !outEof)
      |=> (outPrefix[CSN_W-1:0] > $past(outPrefix[CSN_W-1:0])));

  p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && !outEof) |=> outValid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outPrefix)
                                 && $stable(outSof) && $stable(outEof)));

  p_idle_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && outEof) |=> (!outValid && reqReady));
endmodule

bind frag_builder frag_builder_chk #(.PAY_W(PAY_W), .PFX_W(PFX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outPrefix(outPrefix), .outSof(outSof), .outEof(outEof)
);

// File: tb/frag_builder_test.sv
module frag_builder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [23:0] reqFsn = '0;
  logic [55:0] reqHdr = '0;
  logic [63:0] reqMap = '0;
  logic [5:0] rdAddr;
  logic [383:0] rdData;
  logic outValid;
  logic outReady = 1'b0;
  logic [383:0] outData;
  logic [7:0] outPrefix;
  logic outSof, outEof;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic [383:0] cellPattern(input logic [5:0] a);
    logic [383:0] v;
    for (int k = 0; k < 12; k++) v[k*32 +: 32] = {8'(k*17 + 3), 18'h2B7C1, a};
    return v;
  endfunction

  assign rdData = cellPattern(rdAddr);

  frag_builder uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqFsn(reqFsn), .reqHdr(reqHdr), .reqMap(reqMap),
    .rdAddr(rdAddr), .rdData(rdData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outPrefix(outPrefix), .outSof(outSof), .outEof(outEof)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [383:0] act, input logic [383:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [55:0] hdrOf(input logic [23:0] f);
    return {f, f ^ 24'h5A5A5A, 8'h3C};
  endfunction

  task automatic sendReq(input logic [23:0] f, input logic [63:0] m);
    @(negedge clk);
    chk(reqReady == 1'b1, "R2", "idle reqReady", 384'(reqReady), 384'(1));
    reqValid = 1'b1; reqFsn = f; reqHdr = hdrOf(f); reqMap = m;
    @(negedge clk);
    reqValid = 1'b0; reqFsn = '0; reqHdr = '0; reqMap = '0;
  endtask

  task automatic collect(input logic [23:0] f, input logic [63:0] m, input logic [7:0] pat);
    logic [63:0] rem;
    logic [383:0] expHdr, snapData;
    logic [7:0] snapPfx;
    logic snapSof, snapEof;
    bit haveSnap, headDone, done;
    int firstCyc, lastCyc, e;
    rem = m; haveSnap = 0; headDone = 0; done = 0; firstCyc = 0; lastCyc = 0;
    expHdr = '0; expHdr[23:0] = f; expHdr[87:24] = m; expHdr[143:88] = hdrOf(f);
    for (int cyc = 0; cyc < 600 && !done; cyc++) begin
      @(negedge clk);
      outReady = pat[cyc % 8];
      if (haveSnap) begin
        chk(outValid && outData == snapData && outPrefix == snapPfx &&
            outSof == snapSof && outEof == snapEof, "R7", "hold under stall",
            384'({outValid, outSof, outEof, outPrefix}), 384'({1'b1, snapSof, snapEof, snapPfx}));
        haveSnap = 0;
      end
      if (outValid) begin
        if (!outReady) begin
          snapData = outData; snapPfx = outPrefix; snapSof = outSof; snapEof = outEof;
          haveSnap = 1;
        end else if (!headDone) begin
          chk(outSof && outPrefix == 8'h40, "R3", "header sof/prefix",
              384'({outSof, outPrefix}), 384'({1'b1, 8'h40}));
          chk(outData == expHdr, "R3", "header payload", outData, expHdr);
          chk(outEof == (m == 0), "R6", "header eof", 384'(outEof), 384'(m == 0));
          headDone = 1; firstCyc = cyc; lastCyc = cyc;
          if (m == 0) done = 1;
        end else begin
          e = 0;
          for (int i = 63; i >= 0; i--) if (rem[i]) e = i;
          chk(!outSof && outPrefix == {2'b00, 6'(e)}, "R4", "data prefix",
              384'({outSof, outPrefix}), 384'({1'b0, 2'b00, 6'(e)}));
          chk(outData == cellPattern(6'(e)), "R4", "data payload", outData, cellPattern(6'(e)));
          rem[e] = 1'b0;
          chk(outEof == (rem == 0), "R6", "data eof", 384'(outEof), 384'(rem == 0));
          lastCyc = cyc;
          if (rem == 0) done = 1;
        end
      end
    end
    chk(done, "R4", "fragment completed", 384'(done), 384'(1));
    if (pat == 8'hFF)
      chk(lastCyc - firstCyc == $countones(m), "R5", "no idle cycles",
          384'(lastCyc - firstCyc), 384'($countones(m)));
    @(negedge clk);
    outReady = 1'b0;
    chk(reqReady && !outValid, "R8", "idle after end",
        384'({reqReady, outValid}), 384'({1'b1, 1'b0}));
  endtask

  // fsn, map, ready pattern
  localparam logic [95:0] VEC [6] = '{
    {24'h000001, 64'h0000_0000_0000_0001, 8'hFF},
    {24'h123456, 64'h8000_0000_0000_0000, 8'hFF},
    {24'hABCDEF, 64'h0000_0F00_0000_00A5, 8'hFF},
    {24'hFFFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF},
    {24'h00F00D, 64'h5555_0000_AAAA_0003, 8'b1011_0010},
    {24'h0BEEF0, 64'h0000_0000_0000_0000, 8'h6D}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady && !outValid, "R1", "reset state", 384'({reqReady, outValid}), 384'({1'b1, 1'b0}));
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady && !outValid, "R1", "idle after reset", 384'({reqReady, outValid}), 384'({1'b1, 1'b0}));

    for (int v = 0; v < 6; v++) begin
      sendReq(VEC[v][95:72], VEC[v][71:8]);
      collect(VEC[v][95:72], VEC[v][71:8], VEC[v][7:0]);
    end

    // R2: request during a fragment is ignored
    sendReq(24'h0C0FFE, 64'h0000_0100_0000_0012);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      reqValid = 1'b1; reqFsn = 24'h777777; reqMap = 64'hFFFF; reqHdr = '1;
      chk(!reqReady && outSof && outPrefix == 8'h40, "R2", "busy ignores request",
          384'({reqReady, outSof, outPrefix}), 384'({1'b0, 1'b1, 8'h40}));
    end
    @(negedge clk);
    reqValid = 1'b0; reqFsn = '0; reqMap = '0; reqHdr = '0;
    collect(24'h0C0FFE, 64'h0000_0100_0000_0012, 8'hFF);

    // R1: reset in the middle of a fragment
    sendReq(24'h00ABCD, 64'h00FF);
    @(negedge clk); outReady = 1'b1;
    @(negedge clk); outReady = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(reqReady && !outValid, "R1", "mid-fragment reset", 384'({reqReady, outValid}), 384'({1'b1, 1'b0}));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule